// File: doc/BRIEF.md
# Flash Bus Suspend Arbiter

This block shares a single serial flash bus between two masters. A read master fetches code and data for a cache. A background master runs long program or erase operations. When both are idle or the background work cannot be paused, the arbiter grants the bus by fixed priority, with the read master first. When a read shows up while a pausable program or erase holds the bus, the arbiter takes the bus away from the background master and sends a one-cycle strobe that asks a command sequencer to pause the flash. It then waits a programmable latency and hands the bus to the read master.

After a suspend, the read master keeps the bus for a hold-off window that starts again after every completed read. Back-to-back reads therefore share one suspend instead of each causing a suspend/resume pair. When the window runs out with no read pending, the arbiter sends a resume strobe and gives the bus back to the background master. It then enforces the same latency before it may pause the flash again. A sticky flag reports a suspend issued before the resumed operation got any useful cycle, which is a sign that reads are starving the background operation.

Top module: `flash_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, both grants, both strobes and `starve` are 0. This includes clearing a `starve` flag that was set earlier.
- R2: From idle with both masters requesting, the read master is granted first. The background master is granted only after the read master pulses `rd_done` and drops its request. No suspend or resume strobe is produced.
- R3: When `rd_req` is high while the background master holds the bus with `bg_suspendable`=1 and no latency window is open, `susp_cmd` is high for exactly one cycle. `bg_gnt` is already 0 in that cycle and `rd_gnt` is 0.
- R4: After the `susp_cmd` cycle, `rd_gnt` rises exactly `susp_lat`+1 cycles later. A value of 0 gives the grant in the very next cycle.
- R5: After a suspend, `rd_gnt` stays high while the read master is idle. It drops only once the lock timer reaches zero: `rd_gnt` is high for `lock_dly`+1 cycles after the `rd_done` cycle and low in the cycle after those.
- R6: A read request raised inside the hold-off window sees `rd_gnt` already high, with no new strobe. The window starts again from `lock_dly` at that read's `rd_done`.
- R7: In the first cycle after `rd_gnt` drops at the end of the window, `resume_cmd` is high for one cycle and `bg_gnt` is high.
- R8: After the `resume_cmd` cycle, no `susp_cmd` occurs within the next `susp_lat` cycles, and a read waiting through this window is not granted. If the read is still pending, `susp_cmd` follows `susp_lat`+1 cycles after the resume.
- R9: While the background master holds the bus with `bg_suspendable`=0, a read request is never granted and no suspend is issued. The read is granted in the cycle after the background master's `bg_done` has been seen and its request withdrawn.
- R10: `starve` goes high in the cycle of a `susp_cmd` that follows a resume when the background master had no granted cycle after the latency window closed. It stays high until reset. A suspend with no preceding resume leaves it 0.
- R11: `rd_gnt` and `bg_gnt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read master requests the bus |
| rd_done | input | 1 | One-cycle pulse at the final cycle of a read (with `rd_req` still high) |
| rd_gnt | output | 1 | Bus granted to the read master |
| bg_req | input | 1 | Background master requests the bus for an operation |
| bg_suspendable | input | 1 | The background operation is a program or erase that may be paused |
| bg_done | input | 1 | One-cycle pulse when the background operation completes |
| bg_gnt | output | 1 | Bus granted to the background master |
| susp_lat | input | 16 | Suspend latency in clock cycles |
| lock_dly | input | 16 | Hold-off window length in clock cycles |
| susp_cmd | output | 1 | One-cycle strobe: sequencer sends the suspend command |
| resume_cmd | output | 1 | One-cycle strobe: sequencer sends the resume command |
| starve | output | 1 | Sticky flag: suspend issued before a resumed operation made progress |

## Verification
Arbitration is tried with simultaneous requests from idle, which separates read-first priority from any other order. A read against a non-pausable background operation shows that only program or erase activity is ever interrupted. Suspend sequences run with zero and non-zero latency and hold-off values, and the exact grant and strobe cycles expose off-by-one errors in either timer. A second read inside the hold-off window tells a restarting window from one that runs out on schedule. A read waiting at the moment of resume exercises the post-resume latency and the starve flag together.

// File: rtl/flash_arb_pkg.sv
// Shared types for the flash bus suspend arbiter.
// Assumes: one arbiter state register per instance; encodings are internal only.
package flash_arb_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE  = 3'd0,   // nobody owns the bus
        ARB_READ  = 3'd1,   // plain read, no suspend involved
        ARB_BG    = 3'd2,   // background operation owns the bus
        ARB_SWAIT = 3'd3,   // suspend sent, waiting out the latency
        ARB_LOCK  = 3'd4    // read master holds the bus during hold-off
    } arb_state_t;

endpackage

// File: rtl/arb_countdown.sv
// Loadable down counter that stops at zero.
// Assumes: load takes precedence over dec; zero is a direct decode of the count.
module arb_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    localparam logic [W-1:0] ONE_W = W'(1);

    logic [W-1:0] cnt_q;

    // Count register: reload, decrement toward zero, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - ONE_W;
    end

    // Expiry decode.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/arb_starve_mon.sv
// Tracks whether a resumed background operation made progress before the
// next suspend, and latches a sticky starve flag when it did not.
// Assumes: resume_evt, susp_evt and clear are single-cycle events from the
// arbiter state machine; clear marks completion of the background operation.
module arb_starve_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic resume_evt,
    input  logic run_cycle,
    input  logic susp_evt,
    input  logic clear,
    output logic starve
);
    logic after_res_q;
    logic progressed_q;

    // Remember that the current operation has been resumed at least once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            after_res_q <= 1'b0;
        else if (clear)
            after_res_q <= 1'b0;
        else if (resume_evt)
            after_res_q <= 1'b1;
    end

    // Remember whether a useful background cycle happened since the resume.
    always_ff @(posedge clk) begin
        if (!rst_n)
            progressed_q <= 1'b0;
        else if (resume_evt)
            progressed_q <= 1'b0;
        else if (run_cycle)
            progressed_q <= 1'b1;
    end

    // Sticky flag: a suspend arrived with no progress after a resume.
    always_ff @(posedge clk) begin
        if (!rst_n)
            starve <= 1'b0;
        else if (susp_evt && after_res_q && !progressed_q)
            starve <= 1'b1;
    end

endmodule

// File: rtl/flash_bus_arbiter.sv
// Arbitrates one serial flash bus between a read master and a background
// program/erase master, pausing the background operation for reads.
// Assumes: each master keeps its request high until its done pulse; done
// pulses occur only while that master holds the grant; the latency and
// hold-off values stay stable while a suspend sequence is in flight.
module flash_bus_arbiter
    import flash_arb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             rd_done,
    output logic             rd_gnt,
    input  logic             bg_req,
    input  logic             bg_suspendable,
    input  logic             bg_done,
    output logic             bg_gnt,
    input  logic [CNT_W-1:0] susp_lat,
    input  logic [CNT_W-1:0] lock_dly,
    output logic             susp_cmd,
    output logic             resume_cmd,
    output logic             starve
);
    arb_state_t state_q, state_d;

    logic lat_zero, lock_zero;
    logic suspend_now, resume_now;
    logic lat_load, lat_dec;
    logic lock_load, lock_dec;
    logic run_cycle, bg_finish;
    logic susp_q, resume_q;

    // Event decodes that steer the state machine and both timers.
    always_comb begin
        suspend_now = (state_q == ARB_BG) && rd_req && bg_suspendable
                      && lat_zero && !bg_done;
        resume_now  = (state_q == ARB_LOCK) && lock_zero && !rd_req && !rd_done;
        bg_finish   = (state_q == ARB_BG) && bg_done;
        run_cycle   = (state_q == ARB_BG) && lat_zero && !suspend_now;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (rd_req) state_d = ARB_READ;
                       else if (bg_req) state_d = ARB_BG;
            ARB_READ:  if (rd_done) state_d = ARB_IDLE;
            ARB_BG:    if (bg_done) state_d = ARB_IDLE;
                       else if (suspend_now) state_d = ARB_SWAIT;
            ARB_SWAIT: if (lat_zero) state_d = ARB_LOCK;
            ARB_LOCK:  if (resume_now) state_d = ARB_BG;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Command strobes, one cycle after the deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            susp_q   <= suspend_now;
            resume_q <= resume_now;
        end
    end

    // Timer controls: latency after suspend and after resume; hold-off window.
    always_comb begin
        lat_load  = suspend_now || resume_now;
        lat_dec   = ((state_q == ARB_SWAIT) || (state_q == ARB_BG)) && !lat_load;
        lock_load = ((state_q == ARB_SWAIT) && lat_zero)
                    || ((state_q == ARB_LOCK) && rd_done);
        lock_dec  = (state_q == ARB_LOCK) && !rd_req;
    end

    arb_countdown #(.W(CNT_W)) u_lat_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (susp_lat),
        .dec      (lat_dec),
        .zero     (lat_zero)
    );

    arb_countdown #(.W(CNT_W)) u_lock_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .load_val (lock_dly),
        .dec      (lock_dec),
        .zero     (lock_zero)
    );

    arb_starve_mon u_starve (
        .clk        (clk),
        .rst_n      (rst_n),
        .resume_evt (resume_now),
        .run_cycle  (run_cycle),
        .susp_evt   (suspend_now),
        .clear      (bg_finish),
        .starve     (starve)
    );

    // Grant and strobe outputs decoded from registered state.
    always_comb begin
        rd_gnt     = (state_q == ARB_READ) || (state_q == ARB_LOCK);
        bg_gnt     = (state_q == ARB_BG);
        susp_cmd   = susp_q;
        resume_cmd = resume_q;
    end

endmodule

// File: rtl/flash_bus_arbiter_chk.sv
// Temporal checks on the arbiter's ports, attached by bind.
// Assumes: susp_lat is held constant across each suspend/resume sequence.
module flash_bus_arbiter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_gnt,
    input logic             bg_gnt,
    input logic             bg_suspendable,
    input logic             susp_cmd,
    input logic             resume_cmd,
    input logic             starve,
    input logic [CNT_W-1:0] susp_lat
);
    localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

    logic [CNT_W:0] since_sus_q, since_res_q;
    logic           suspended_q, seen_res_q;

    // Cycle counters since the most recent strobes, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_sus_q <= '1;
            since_res_q <= '1;
        end else begin
            if (susp_cmd) since_sus_q <= ONE_X;
            else if (since_sus_q != '1) since_sus_q <= since_sus_q + ONE_X;
            if (resume_cmd) since_res_q <= ONE_X;
            else if (since_res_q != '1) since_res_q <= since_res_q + ONE_X;
        end
    end

    // Phase flags: inside a suspend, and a resume has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            suspended_q <= 1'b0;
            seen_res_q  <= 1'b0;
        end else begin
            if (susp_cmd) suspended_q <= 1'b1;
            else if (resume_cmd) suspended_q <= 1'b0;
            if (resume_cmd) seen_res_q <= 1'b1;
        end
    end

    p_grant_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_gnt && bg_gnt));

    p_susp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        susp_cmd |=> !susp_cmd);

    p_susp_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        susp_cmd |-> (!bg_gnt && !rd_gnt));

    p_grant_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_q && $rose(rd_gnt)) |-> (since_sus_q == ({1'b0, susp_lat} + ONE_X)));

    p_resume_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_cmd |-> (bg_gnt && $past(rd_gnt)));

    p_resume_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_cmd |=> !resume_cmd);

    p_resume_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_cmd && seen_res_q) |-> (since_res_q > {1'b0, susp_lat}));

    p_only_pausable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        susp_cmd |-> $past(bg_suspendable));

    p_starve_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> starve);

endmodule

bind flash_bus_arbiter flash_bus_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_gnt         (rd_gnt),
    .bg_gnt         (bg_gnt),
    .bg_suspendable (bg_suspendable),
    .susp_cmd       (susp_cmd),
    .resume_cmd     (resume_cmd),
    .starve         (starve),
    .susp_lat       (susp_lat)
);

// File: tb/flash_bus_arbiter_test.sv
// Directed bench: one task per scenario, each checking its own results.
module flash_bus_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0, rd_done = 1'b0;
    logic        bg_req = 1'b0, bg_ok = 1'b0, bg_done = 1'b0;
    logic [15:0] susp_lat = '0, lock_dly = '0;
    logic        rd_gnt, bg_gnt, susp_cmd, resume_cmd, starve;

    int checks = 0;
    int failures = 0;
    int n_susp = 0;
    int n_res = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_done(rd_done), .rd_gnt(rd_gnt),
        .bg_req(bg_req), .bg_suspendable(bg_ok), .bg_done(bg_done), .bg_gnt(bg_gnt),
        .susp_lat(susp_lat), .lock_dly(lock_dly),
        .susp_cmd(susp_cmd), .resume_cmd(resume_cmd), .starve(starve)
    );

    // Strobe tallies, sampled at the edge (values of the ending cycle).
    always @(posedge clk) begin
        if (susp_cmd)   n_susp <= n_susp + 1;
        if (resume_cmd) n_res  <= n_res + 1;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rd_req = 0; rd_done = 0; bg_req = 0; bg_ok = 0; bg_done = 0;
        repeat (3) tick();
        chk("R1 rd_gnt in reset", rd_gnt, 0);
        chk("R1 bg_gnt in reset", bg_gnt, 0);
        chk("R1 strobes in reset", susp_cmd | resume_cmd, 0);
        chk("R1 starve in reset", starve, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 grants after reset", rd_gnt | bg_gnt, 0);
    endtask

    task automatic t_priority_r2();
        int s0 = n_susp, r0 = n_res;
        rd_req = 1; bg_req = 1; bg_ok = 0;
        tick();
        chk("R2 read first", rd_gnt, 1);
        chk("R2 background waits", bg_gnt, 0);
        rd_done = 1;
        tick();
        rd_done = 0; rd_req = 0;
        tick();
        chk("R2 background after read", bg_gnt, 1);
        bg_done = 1;
        tick();
        bg_done = 0; bg_req = 0;
        tick();
        chk("R2 no suspend strobes", n_susp - s0, 0);
        chk("R2 no resume strobes", n_res - r0, 0);
    endtask

    task automatic t_nonpausable_r9();
        int s0 = n_susp;
        bg_req = 1; bg_ok = 0;
        tick();
        chk("R9 background granted", bg_gnt, 1);
        rd_req = 1;
        repeat (10) tick();
        chk("R9 read not granted", rd_gnt, 0);
        chk("R9 background kept", bg_gnt, 1);
        chk("R9 no suspend", n_susp - s0, 0);
        bg_done = 1;
        tick();
        bg_done = 0; bg_req = 0;
        tick();
        chk("R9 read granted after done", rd_gnt, 1);
        rd_done = 1;
        tick();
        rd_done = 0; rd_req = 0;
        tick();
    endtask

    // Start a pausable operation, raise a read, check suspend and latency.
    task automatic start_and_suspend(input int lat, input string tag);
        int k = 0;
        bg_req = 1; bg_ok = 1;
        tick();
        chk({tag, " background granted"}, bg_gnt, 1);
        repeat (lat + 3) tick();
        rd_req = 1;
        tick();
        chk("R3 suspend strobe", susp_cmd, 1);
        chk("R3 background released", bg_gnt, 0);
        chk("R3 read not yet granted", rd_gnt, 0);
        while (!rd_gnt && k < 300) begin
            tick();
            k++;
            if (k == 1) chk("R3 strobe is one cycle", susp_cmd, 0);
        end
        chk("R4 grant latency", k, lat + 1);
    endtask

    // Complete the current read, then expect hold-off and resume.
    task automatic done_and_resume(input int lk, input string tag);
        int k = 1;
        rd_done = 1;
        tick();
        rd_done = 0; rd_req = 0;
        chk({tag, " held after done"}, rd_gnt, 1);
        while (rd_gnt && k < 300) begin
            tick();
            k++;
        end
        chk({tag, " hold-off length"}, k, lk + 2);
        chk("R7 resume strobe", resume_cmd, 1);
        chk("R7 background regranted", bg_gnt, 1);
    endtask

    task automatic finish_bg(input int lat);
        repeat (lat + 3) tick();
        bg_done = 1;
        tick();
        bg_done = 0; bg_req = 0;
        tick();
        chk("R9 bus idle after done", rd_gnt | bg_gnt, 0);
    endtask

    task automatic t_suspend_basic(input int lat, input int lk);
        susp_lat = 16'(lat); lock_dly = 16'(lk);
        start_and_suspend(lat, "R3");
        chk("R10 no starve on first suspend", starve, 0);
        repeat (2) tick();
        done_and_resume(lk, "R5");
        tick();
        chk("R7 resume is one cycle", resume_cmd, 0);
        finish_bg(lat);
    endtask

    task automatic t_lock_restart_r6();
        int r0;
        susp_lat = 16'd2; lock_dly = 16'd6;
        start_and_suspend(2, "R6");
        tick();
        rd_done = 1;
        tick();
        rd_done = 0; rd_req = 0;
        repeat (2) tick();
        r0 = n_res;
        chk("R6 still held in window", rd_gnt, 1);
        rd_req = 1;
        tick();
        chk("R6 new read served at once", rd_gnt, 1);
        tick();
        chk("R6 no resume during window", n_res - r0, 0);
        done_and_resume(6, "R6");
        finish_bg(2);
    endtask

    task automatic t_window_r8();
        susp_lat = 16'd5; lock_dly = 16'd1;
        start_and_suspend(5, "R8");
        tick();
        done_and_resume(1, "R8");
        rd_req = 1;
        for (int j = 1; j <= 5; j++) begin
            tick();
            chk("R8 read stalled in window", rd_gnt, 0);
            chk("R8 no suspend in window", susp_cmd, 0);
        end
        tick();
        chk("R8 suspend after window", susp_cmd, 1);
        chk("R10 starve raised", starve, 1);
        while (!rd_gnt) tick();
        tick();
        done_and_resume(1, "R8");
        finish_bg(5);
        chk("R10 starve sticky", starve, 1);
        t_reset();
        chk("R1 starve cleared by reset", starve, 0);
    endtask

    initial begin
        t_reset();
        t_priority_r2();
        t_nonpausable_r9();
        t_suspend_basic(3, 4);
        t_suspend_basic(0, 0);
        t_lock_restart_r6();
        t_window_r8();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule